// File: doc/BRIEF.md
# Tower-Field GF(2^12) Multiplier with Power Sequencer

This block multiplies two 12-bit elements of GF(2^12). The larger field is not reduced by a single degree-12 polynomial. It is built as a quadratic extension of GF(2^6): each operand splits into a 6-bit upper half and a 6-bit lower half, and the product is formed from a few GF(2^6) multiplies. The multiply path is purely combinational, from the operand inputs to the product output.

The same multiplier core also drives a small power sequencer. A start pulse loads the value 1. After that, every cycle with the step enable high multiplies the held value by the fixed constant 0xE01 and presents the result as a new power. When the sequence comes back to 1, the block raises a wrap flag for one cycle and then returns to idle. Walking the sequence this way lists, in order, the antilog entries that a Reed-Solomon codec needs for its log and antilog tables.

The sequencer is a three-state machine:
- **SEQ_IDLE** waits for a start pulse. On start it moves to **SEQ_RUN** (transition *launch*).
- **SEQ_RUN** steps on each enabled cycle (*step*) and holds its value on a disabled cycle (*pause*). When a step produces the value 1 it moves to **SEQ_WRAP** (*close*).
- **SEQ_WRAP** lasts one cycle and always moves back to **SEQ_IDLE** (*retire*).

Top module: `gf4096_unit`

## Requirements
- R1: The GF(2^6) subfield multiply uses the reduction x^6+x+1. In shift-and-add form, a carry out of bit 5 of the shifted operand is cancelled by XOR with 0x43 (which leaves 0x03 in the low six bits).
- R2: `prod` equals a tower product. The upper half [11:6] is m(ah^al, bh^bl) ^ m(al,bl). The lower half [5:0] is m(m(ah,bh), 0x21) ^ m(al,bl). Here m is the R1 multiply and the operand halves are bits [11:6] and [5:0]. The element 0x001 is the identity.
- R3: `prod` is 0 whenever `op_a` or `op_b` is 0.
- R4: `prod` for (a,b) equals `prod` for (b,a).
- R5: A `seq_start` pulse sampled in SEQ_IDLE gives `pow_value`=1 with `pow_valid`=1 and `pow_wrap`=0 after that clock edge.
- R6: In SEQ_RUN, each edge with `seq_en`=1 replaces `pow_value` by the R2 product of `pow_value` and 0xE01, and sets `pow_valid`=1.
- R7: In SEQ_RUN, an edge with `seq_en`=0 leaves `pow_value` unchanged and clears `pow_valid`.
- R8: When a step yields 1, `pow_wrap`=1 and `pow_valid`=1 with `pow_value`=1 for exactly one cycle. The block is then idle, with `pow_valid`=0 and `pow_wrap`=0.
- R9: `seq_start` is ignored outside SEQ_IDLE. `pow_value` does not reload to 1.
- R10: After reset (`rst_n` low, asynchronous), `pow_value`=1 and `pow_valid`=0, `pow_wrap`=0, `seq_busy`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 12 | Multiplicand |
| op_b | input | 12 | Multiplier |
| prod | output | 12 | Combinational product op_a*op_b |
| seq_start | input | 1 | Start the power sequence (honoured in idle only) |
| seq_en | input | 1 | Step enable for the power sequence |
| pow_value | output | 12 | Current power of 0xE01 |
| pow_valid | output | 1 | A new power was produced at the last edge |
| pow_wrap | output | 1 | The sequence has returned to 1 |
| seq_busy | output | 1 | Sequencer not idle |

## Verification
On every cycle, assertions check the following:
- a zero operand forces a zero product;
- a launch loads the value 1;
- an enabled step always changes the value;
- a paused step holds it;
- the wrap flag only appears with the value 1 and is followed by idle.

Only the bench scenarios can show that the product values match the tower formula, that the two operand orders agree, and that the wrap lands on the exact step count. The bench checks these against an independent polynomial-product reference model. It also walks the whole power sequence and confirms that a start pulse is ignored in the middle of a run.

// File: rtl/gf_tower_pkg.sv
package gf_tower_pkg;
    localparam int HALF_W    = 6;
    localparam int FULL_W    = 2 * HALF_W;
    localparam logic [HALF_W-1:0] SUB_TAIL  = 6'h03;
    localparam logic [HALF_W-1:0] SUB_CONST = 6'h21;
    localparam logic [FULL_W-1:0] STEP_K    = 12'hE01;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RUN  = 2'd1,
        SEQ_WRAP = 2'd2
    } seq_state_e;
endpackage

// File: rtl/gf64_mul.sv
module gf64_mul #(
    parameter int HW = 6,
    parameter logic [HW-1:0] TAIL = 6'h03
) (
    input  logic [HW-1:0] x,
    input  logic [HW-1:0] y,
    output logic [HW-1:0] z
);
    logic [HW-1:0] acc [0:HW];
    logic [HW-1:0] sx  [0:HW];
    logic [HW-1:0] sy  [0:HW];

    assign acc[0] = '0;
    assign sx[0]  = x;
    assign sy[0]  = y;

    // R1: one shift-and-add iteration per bit of x
    for (genvar i = 0; i < HW; i++) begin : g_iter
        assign acc[i+1] = sx[i][0] ? (acc[i] ^ sy[i]) : acc[i];
        assign sx[i+1]  = sx[i] >> 1;
        assign sy[i+1]  = {sy[i][HW-2:0], 1'b0} ^ (sy[i][HW-1] ? TAIL : '0);
    end

    assign z = acc[HW];
endmodule

// File: rtl/gf4096_mul.sv
module gf4096_mul #(
    parameter int HW = 6,
    parameter logic [HW-1:0] TAIL  = 6'h03,
    parameter logic [HW-1:0] CMULT = 6'h21,
    localparam int FW = 2 * HW
) (
    input  logic [FW-1:0] a,
    input  logic [FW-1:0] b,
    output logic [FW-1:0] p
);
    logic [HW-1:0] a_hi, a_lo, b_hi, b_lo;
    logic [HW-1:0] m_sum, m_low, m_high, m_scaled;

    assign a_hi = a[FW-1:HW];
    assign a_lo = a[HW-1:0];
    assign b_hi = b[FW-1:HW];
    assign b_lo = b[HW-1:0];

    gf64_mul #(.HW(HW), .TAIL(TAIL)) u_sum   (.x(a_hi ^ a_lo), .y(b_hi ^ b_lo), .z(m_sum));
    gf64_mul #(.HW(HW), .TAIL(TAIL)) u_low   (.x(a_lo),        .y(b_lo),        .z(m_low));
    gf64_mul #(.HW(HW), .TAIL(TAIL)) u_high  (.x(a_hi),        .y(b_hi),        .z(m_high));
    gf64_mul #(.HW(HW), .TAIL(TAIL)) u_scale (.x(m_high),      .y(CMULT),       .z(m_scaled));

    // R2: tower combination
    assign p = {m_sum ^ m_low, m_scaled ^ m_low};
endmodule

// File: rtl/gf_pow_seq.sv
module gf_pow_seq
    import gf_tower_pkg::*;
#(
    parameter int FW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          en,
    input  logic [FW-1:0] next_pow,
    output logic [FW-1:0] cur_pow,
    output logic          valid,
    output logic          wrap,
    output logic          busy
);
    localparam logic [FW-1:0] ONE = FW'(1);

    seq_state_e    state_q, state_d;
    logic [FW-1:0] pow_q, pow_d;
    logic          new_q, new_d;

    always_comb begin
        state_d = state_q;
        pow_d   = pow_q;
        new_d   = 1'b0;
        unique case (state_q)
            SEQ_IDLE: if (start) begin
                state_d = SEQ_RUN;
                pow_d   = ONE;
                new_d   = 1'b1;
            end
            SEQ_RUN: if (en) begin
                pow_d = next_pow;
                new_d = 1'b1;
                if (next_pow == ONE) state_d = SEQ_WRAP;
            end
            SEQ_WRAP: state_d = SEQ_IDLE;
            default:  state_d = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            pow_q   <= ONE;
            new_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            pow_q   <= pow_d;
            new_q   <= new_d;
        end
    end

    always_comb begin
        cur_pow = pow_q;
        valid   = new_q;
        wrap    = (state_q == SEQ_WRAP);
        busy    = (state_q != SEQ_IDLE);
    end

    a_r5_launch_loads_one: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_IDLE && start) |=> (cur_pow == ONE && valid));
    a_r6_step_changes: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_RUN && en) |=> (cur_pow != $past(cur_pow)));
    a_r7_pause_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_RUN && !en) |=> ($stable(cur_pow) && !valid));
    a_r8_wrap_is_one: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |-> (cur_pow == ONE && valid));
    a_r8_wrap_retires: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (!busy && !wrap && !valid));
endmodule

// File: rtl/gf4096_unit.sv
module gf4096_unit
    import gf_tower_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FULL_W-1:0] op_a,
    input  logic [FULL_W-1:0] op_b,
    output logic [FULL_W-1:0] prod,
    input  logic              seq_start,
    input  logic              seq_en,
    output logic [FULL_W-1:0] pow_value,
    output logic              pow_valid,
    output logic              pow_wrap,
    output logic              seq_busy
);
    logic [FULL_W-1:0] step_val;

    gf4096_mul #(.HW(HALF_W), .TAIL(SUB_TAIL), .CMULT(SUB_CONST)) u_mul (
        .a(op_a), .b(op_b), .p(prod)
    );

    gf4096_mul #(.HW(HALF_W), .TAIL(SUB_TAIL), .CMULT(SUB_CONST)) u_step (
        .a(pow_value), .b(STEP_K), .p(step_val)
    );

    gf_pow_seq #(.FW(FULL_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(seq_start), .en(seq_en),
        .next_pow(step_val), .cur_pow(pow_value), .valid(pow_valid),
        .wrap(pow_wrap), .busy(seq_busy)
    );

    a_r3_zero_operand: assert property (@(posedge clk) disable iff (!rst_n)
        (op_a == '0 || op_b == '0) |-> (prod == '0));
    a_r2_identity: assert property (@(posedge clk) disable iff (!rst_n)
        (op_a == FULL_W'(1)) |-> (prod == op_b));
endmodule

// File: tb/sim_gf4096_unit.sv
module sim_gf4096_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] op_a = '0, op_b = '0;
    logic [11:0] prod;
    logic        seq_start = 1'b0, seq_en = 1'b0;
    logic [11:0] pow_value;
    logic        pow_valid, pow_wrap, seq_busy;

    int n_chk = 0;
    int n_bad = 0;
    int order_k = 0;
    logic [23:0] lfsr = 24'h5A3C91;

    always #4 clk = ~clk;

    gf4096_unit u0 (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .prod(prod),
        .seq_start(seq_start), .seq_en(seq_en), .pow_value(pow_value),
        .pow_valid(pow_valid), .pow_wrap(pow_wrap), .seq_busy(seq_busy)
    );

    // reference: full polynomial product, then reduce high bits by x^6+x+1
    function automatic logic [5:0] ref64(input logic [5:0] x, input logic [5:0] y);
        logic [10:0] t = '0;
        for (int i = 0; i < 6; i++) if (y[i]) t ^= 11'(x) << i;
        for (int i = 10; i >= 6; i--) if (t[i]) t ^= 11'(7'h43) << (i - 6);
        return t[5:0];
    endfunction

    function automatic logic [11:0] ref4096(input logic [11:0] x, input logic [11:0] y);
        logic [5:0] lo_m = ref64(x[5:0], y[5:0]);
        logic [5:0] hi = ref64(x[11:6] ^ x[5:0], y[11:6] ^ y[5:0]) ^ lo_m;
        logic [5:0] lo = ref64(ref64(x[11:6], y[11:6]), 6'h21) ^ lo_m;
        return {hi, lo};
    endfunction

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%03h expected=%03h", req, act, exp);
        end
    endtask

    task automatic next_rand();
        lfsr = {lfsr[22:0], lfsr[23] ^ lfsr[22] ^ lfsr[21] ^ lfsr[16]};
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        seq_start = 1'b0; seq_en = 1'b0;
        repeat (2) @(negedge clk);
        check("R10 value", pow_value, 12'h001);
        check("R10 valid", 12'(pow_valid), 12'h0);
        check("R10 wrap", 12'(pow_wrap), 12'h0);
        check("R10 busy", 12'(seq_busy), 12'h0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_fixed_products();
        op_a = 12'h001; op_b = 12'hABC; #1;
        check("R2 identity", prod, 12'hABC);
        op_a = 12'h020; op_b = 12'h002; #1;   // low half: x^5 * x wraps through R1 reduction
        check("R1 reduce", prod, 12'h003);
        op_a = 12'h040; op_b = 12'h040; #1;
        check("R2 high halves", prod, ref4096(12'h040, 12'h040));
        op_a = 12'hFFF; op_b = 12'hE01; #1;
        check("R2 full", prod, ref4096(12'hFFF, 12'hE01));
    endtask

    task automatic t_random_products();
        for (int i = 0; i < 300; i++) begin
            next_rand(); op_a = lfsr[11:0]; op_b = lfsr[23:12]; #1;
            check("R2 random", prod, ref4096(lfsr[11:0], lfsr[23:12]));
            op_a = lfsr[23:12]; op_b = lfsr[11:0]; #1;
            check("R4 swapped", prod, ref4096(lfsr[11:0], lfsr[23:12]));
        end
    endtask

    task automatic t_zero();
        for (int i = 0; i < 20; i++) begin
            next_rand();
            op_a = 12'h000; op_b = lfsr[11:0]; #1;
            check("R3 a zero", prod, 12'h000);
            op_a = lfsr[11:0]; op_b = 12'h000; #1;
            check("R3 b zero", prod, 12'h000);
        end
    endtask

    task automatic t_full_sequence();
        logic [11:0] expv = 12'h001;
        @(negedge clk);
        seq_start = 1'b1;
        @(negedge clk);
        seq_start = 1'b0;
        check("R5 value", pow_value, 12'h001);
        check("R5 valid", 12'(pow_valid), 12'h1);
        check("R5 wrap", 12'(pow_wrap), 12'h0);
        seq_en = 1'b1;
        for (int k = 1; k <= order_k; k++) begin
            @(negedge clk);
            expv = ref4096(expv, 12'hE01);
            check("R6 power", pow_value, expv);
            check("R6 valid", 12'(pow_valid), 12'h1);
            check("R8 wrap flag", 12'(pow_wrap), (k == order_k) ? 12'h1 : 12'h0);
        end
        seq_en = 1'b0;
        @(negedge clk);
        check("R8 idle valid", 12'(pow_valid), 12'h0);
        check("R8 idle wrap", 12'(pow_wrap), 12'h0);
        check("R8 idle busy", 12'(seq_busy), 12'h0);
    endtask

    task automatic t_pause_restart();
        logic [11:0] expv = 12'h001;
        seq_start = 1'b1;
        @(negedge clk);
        seq_start = 1'b0;
        seq_en = 1'b1;
        repeat (3) begin
            @(negedge clk);
            expv = ref4096(expv, 12'hE01);
        end
        check("R6 three steps", pow_value, expv);
        seq_en = 1'b0;
        repeat (2) begin
            @(negedge clk);
            check("R7 held", pow_value, expv);
            check("R7 valid low", 12'(pow_valid), 12'h0);
        end
        seq_start = 1'b1;
        @(negedge clk);
        seq_start = 1'b0;
        check("R9 start ignored", pow_value, expv);
        check("R9 still busy", 12'(seq_busy), 12'h1);
        seq_en = 1'b1;
        @(negedge clk);
        seq_en = 1'b0;
        expv = ref4096(expv, 12'hE01);
        check("R9 continues", pow_value, expv);
    endtask

    initial begin
        logic [11:0] v = ref4096(12'h001, 12'hE01);
        order_k = 1;
        while (v != 12'h001 && order_k < 5000) begin
            v = ref4096(v, 12'hE01);
            order_k++;
        end
        t_reset();
        t_fixed_products();
        t_random_products();
        t_zero();
        t_full_sequence();
        t_pause_restart();
        t_reset();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule